// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves one branch per transaction for a 32-bit processor core. An upstream stage hands it a branch kind and the immediate fields already cut out of the instruction word. It also supplies the current program counter, the condition register, the count register and a register-held target. The block decides whether the branch is taken and computes the next program counter. It also produces the new count value and a write strobe for it, so a later stage can commit the count register without any further work.

Transactions arrive on a valid/ready input channel and leave on a valid/ready output channel. The block holds one result in a single output register. An input is accepted in a cycle when `in_valid` is high and `in_ready` is high, and its result is visible on the output channel from the next cycle. `in_ready` is high when the output register is empty or when the downstream stage is taking its content in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new input is taken. There is no skid buffer, so a stall reaches the input channel in the same cycle.

Kind codes on `in_kind` are as follows. 0 is an unconditional PC-relative branch and 1 an unconditional absolute branch. 2 is a conditional PC-relative branch, 3 a conditional absolute branch and 4 a conditional branch to the register target. Codes 5 to 7 are reserved.

Top module: `branch_resolve`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Kind 0 is always taken. Its target is `in_pc` plus the value `{in_li, 2'b00}` read as a 26-bit two's-complement number and sign-extended from bit 25 to 32 bits.
- R3: Kind 1 is always taken. Its target is the sign-extended value of R2 on its own, without `in_pc` added.
- R4: Kinds 2 and 3 use the value `{in_bd, 2'b00}` read as a 16-bit two's-complement number and sign-extended from bit 15. Kind 2 adds it to `in_pc`, while kind 3 uses it on its own as the target.
- R5: Kind 4 uses `in_reg` as the target, with bits 1 and 0 forced to zero.
- R6: For a conditional kind with `in_bo[2]` set, the count test passes, `out_ctr` equals `in_ctr` and `out_ctr_we` is 0.
- R7: For a conditional kind with `in_bo[2]` clear, `out_ctr` is `in_ctr - 1` (mod 2^32) and `out_ctr_we` is 1 whether or not the branch is taken. The count test passes when the new count is nonzero and `in_bo[1]` is 0, or when it is zero and `in_bo[1]` is 1.
- R8: For a conditional kind, the condition test passes when `in_bo[4]` is set. Otherwise it passes when `in_cr[31 - in_bi]` equals `in_bo[3]`. A conditional branch is taken only when both the count test and the condition test pass.
- R9: When a branch is not taken, `out_npc` is `in_pc + 4`.
- R10: An accepted input gives `out_valid` in the next cycle. `out_valid` and all result fields hold steady while `out_ready` is low, and `in_ready` equals `!out_valid || out_ready`.
- R11: Unconditional kinds and reserved kinds never write the count, and they pass `in_ctr` through unchanged. Reserved kinds 5 to 7 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_kind | input | 3 | Branch kind code |
| in_li | input | 24 | Long displacement field for unconditional kinds |
| in_bd | input | 14 | Short displacement field for conditional kinds |
| in_bo | input | 5 | Branch options field |
| in_bi | input | 5 | Condition register bit index, counted from the MSB |
| in_pc | input | 32 | Address of the branch |
| in_cr | input | 32 | Condition register |
| in_ctr | input | 32 | Count register |
| in_reg | input | 32 | Register-held target |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream stage takes the result |
| out_taken | output | 1 | Branch taken |
| out_npc | output | 32 | Next program counter |
| out_ctr | output | 32 | New count value |
| out_ctr_we | output | 1 | Count write enable |

## Verification
A wrong decision in this block is purely combinational before the single output register. A bad sign-extension point, a wrongly chosen condition bit or an inverted count test therefore shows on `out_taken`, `out_npc` or `out_ctr` in the very cycle after acceptance. A fault in the output register or the handshake shows differently. It appears as a result that changes while it is stalled, a lost or doubled result, or an `in_ready` that disagrees with `!out_valid || out_ready`, and each of these is visible within one cycle of the stall or acceptance. Directed edge cases cover the most negative and most positive displacements, condition bit indices 0 and 31, and counts of 1 and 0.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    BK_UNC_REL  = 3'd0,
    BK_UNC_ABS  = 3'd1,
    BK_CND_REL  = 3'd2,
    BK_CND_ABS  = 3'd3,
    BK_CND_REG  = 3'd4
  } br_kind_e;

  // Option bit positions inside the 5-bit options field; neighbours rely on them.
  localparam int OPT_CR_IGNORE  = 4;
  localparam int OPT_CR_WANT    = 3;
  localparam int OPT_CTR_SKIP   = 2;
  localparam int OPT_CTR_ZERO   = 1;

  function automatic logic kind_is_cond(input logic [2:0] k);
    return (k == BK_CND_REL) || (k == BK_CND_ABS) || (k == BK_CND_REG);
  endfunction

  function automatic logic kind_is_unc(input logic [2:0] k);
    return (k == BK_UNC_REL) || (k == BK_UNC_ABS);
  endfunction

endpackage

// File: rtl/brc_sext.sv
module brc_sext #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  fld,
  output logic [OUT_W-1:0] ext
);
  localparam int SH_W = IN_W + 2;

  logic [SH_W-1:0] shifted;
  assign shifted = {fld, 2'b00};

  generate
    if (OUT_W > SH_W) begin : g_extend
      assign ext = {{(OUT_W-SH_W){shifted[SH_W-1]}}, shifted};
    end else begin : g_trunc
      assign ext = shifted[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LI_W = 24,
  parameter int BD_W = 14
) (
  input  logic [2:0]      kind,
  input  logic [LI_W-1:0] li,
  input  logic [BD_W-1:0] bd,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rg,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] fallthru
);
  logic [XLEN-1:0] long_off;
  logic [XLEN-1:0] short_off;
  logic [1:0]      unused_rg_low;

  brc_sext #(.IN_W(LI_W), .OUT_W(XLEN)) u_long  (.fld(li), .ext(long_off));
  brc_sext #(.IN_W(BD_W), .OUT_W(XLEN)) u_short (.fld(bd), .ext(short_off));

  assign unused_rg_low = rg[1:0];
  assign fallthru      = pc + XLEN'(4);

  always_comb begin
    case (kind)
      BK_UNC_REL: target = pc + long_off;
      BK_UNC_ABS: target = long_off;
      BK_CND_REL: target = pc + short_off;
      BK_CND_ABS: target = short_off;
      BK_CND_REG: target = {rg[XLEN-1:2], 2'b00};
      default:    target = fallthru;
    endcase
  end
endmodule

// File: rtl/brc_ctr_test.sv
module brc_ctr_test #(
  parameter int XLEN = 32
) (
  input  logic            skip,
  input  logic            want_zero,
  input  logic [XLEN-1:0] ctr,
  output logic [XLEN-1:0] ctr_next,
  output logic            dec_en,
  output logic            pass
);
  logic [XLEN-1:0] dec_val;
  logic            is_zero;

  assign dec_val  = ctr - XLEN'(1);
  assign is_zero  = (dec_val == '0);
  assign dec_en   = !skip;
  assign ctr_next = skip ? ctr : dec_val;
  assign pass     = skip | (is_zero == want_zero);
endmodule

// File: rtl/brc_cr_test.sv
module brc_cr_test #(
  parameter int BI_W = 5
) (
  input  logic [(1<<BI_W)-1:0] cr,
  input  logic [BI_W-1:0]      bi,
  input  logic                 ignore,
  input  logic                 want,
  output logic                 pass
);
  localparam int CR_W = 1 << BI_W;

  logic [BI_W-1:0] pos;
  assign pos  = BI_W'(CR_W - 1) - bi;
  assign pass = ignore | (cr[pos] == want);
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import brc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LI_W = 24,
  parameter int BD_W = 14,
  parameter int BO_W = 5,
  parameter int BI_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [LI_W-1:0]   in_li,
  input  logic [BD_W-1:0]   in_bd,
  input  logic [BO_W-1:0]   in_bo,
  input  logic [BI_W-1:0]   in_bi,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_cr,
  input  logic [XLEN-1:0]   in_ctr,
  input  logic [XLEN-1:0]   in_reg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_npc,
  output logic [XLEN-1:0]   out_ctr,
  output logic              out_ctr_we
);
  localparam int CR_W = 1 << BI_W;

  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] ctr_upd;
  logic            ctr_dec;
  logic            ctr_ok;
  logic            cr_ok;
  logic            is_cond;
  logic            is_unc;
  logic            take;
  logic            accept;
  logic            unused_hint;
  logic [CR_W-1:0] cr_view;

  assign unused_hint = in_bo[0];
  assign is_cond     = kind_is_cond(in_kind);
  assign is_unc      = kind_is_unc(in_kind);
  assign cr_view     = CR_W'(in_cr);

  brc_target #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .kind(in_kind), .li(in_li), .bd(in_bd), .pc(in_pc), .rg(in_reg),
    .target(tgt), .fallthru(seq_pc)
  );

  brc_ctr_test #(.XLEN(XLEN)) u_ctr (
    .skip(in_bo[OPT_CTR_SKIP]), .want_zero(in_bo[OPT_CTR_ZERO]), .ctr(in_ctr),
    .ctr_next(ctr_upd), .dec_en(ctr_dec), .pass(ctr_ok)
  );

  brc_cr_test #(.BI_W(BI_W)) u_cr (
    .cr(cr_view), .bi(in_bi), .ignore(in_bo[OPT_CR_IGNORE]),
    .want(in_bo[OPT_CR_WANT]), .pass(cr_ok)
  );

  assign take     = is_unc | (is_cond & ctr_ok & cr_ok);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_npc    <= '0;
      out_ctr    <= '0;
      out_ctr_we <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_taken  <= take;
      out_npc    <= take ? tgt : seq_pc;
      out_ctr    <= is_cond ? ctr_upd : in_ctr;
      out_ctr_we <= is_cond & ctr_dec;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int XLEN = 32,
  parameter int BO_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_kind,
  input logic [BO_W-1:0] in_bo,
  input logic [XLEN-1:0] in_pc,
  input logic [XLEN-1:0] in_ctr,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [XLEN-1:0] out_npc,
  input logic [XLEN-1:0] out_ctr,
  input logic            out_ctr_we
);
  logic acc;
  logic cnd;
  logic unc;
  assign acc = in_valid && in_ready;
  assign cnd = (in_kind == 3'd2) || (in_kind == 3'd3) || (in_kind == 3'd4);
  assign unc = (in_kind == 3'd0) || (in_kind == 3'd1);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_npc) && $stable(out_taken)
                                   && $stable(out_ctr) && $stable(out_ctr_we)));
  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnd && in_bo[2]) |=> (!out_ctr_we && out_ctr == $past(in_ctr)));
  assert_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnd && !in_bo[2]) |=> (out_ctr_we && out_ctr == $past(in_ctr) - XLEN'(1)));
  assert_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnd && in_bo[2] && in_bo[4]) |=> out_taken);
  assert_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_taken || out_npc == $past(in_pc) + XLEN'(4)));
  assert_unc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && unc) |=> (out_taken && !out_ctr_we));
endmodule

bind branch_resolve brc_checker #(.XLEN(XLEN), .BO_W(BO_W)) u_brc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .in_bo(in_bo), .in_pc(in_pc), .in_ctr(in_ctr),
  .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
  .out_npc(out_npc), .out_ctr(out_ctr), .out_ctr_we(out_ctr_we)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [23:0] in_li = '0;
  logic [13:0] in_bd = '0;
  logic [4:0]  in_bo = '0;
  logic [4:0]  in_bi = '0;
  logic [31:0] in_pc = '0, in_cr = '0, in_ctr = '0, in_reg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [31:0] out_npc, out_ctr;
  logic        out_ctr_we;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    logic [31:0] ctr;
    logic        we;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  branch_resolve uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_li(in_li), .in_bd(in_bd), .in_bo(in_bo), .in_bi(in_bi),
    .in_pc(in_pc), .in_cr(in_cr), .in_ctr(in_ctr), .in_reg(in_reg),
    .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
    .out_npc(out_npc), .out_ctr(out_ctr), .out_ctr_we(out_ctr_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] k, input logic [23:0] li,
      input logic [13:0] bd, input logic [4:0] bo, input logic [4:0] bi,
      input logic [31:0] pc, input logic [31:0] cr, input logic [31:0] ctr,
      input logic [31:0] rg);
    exp_t e;
    int lo = int'($signed({li, 2'b00}));
    int so = int'($signed({bd, 2'b00}));
    logic [31:0] nc = ctr - 32'd1;
    logic c_ok = bo[2] ? 1'b1 : ((nc != 0) != bo[1]);
    logic r_ok = bo[4] ? 1'b1 : (cr[31 - bi] == bo[3]);
    logic [31:0] tg;
    logic cond = (k >= 3'd2) && (k <= 3'd4);
    case (k)
      3'd0: tg = pc + 32'(lo);
      3'd1: tg = 32'(lo);
      3'd2: tg = pc + 32'(so);
      3'd3: tg = 32'(so);
      default: tg = rg & 32'hFFFF_FFFC;
    endcase
    e.taken = (k <= 3'd1) ? 1'b1 : (cond && c_ok && r_ok);
    e.npc   = e.taken ? tg : pc + 32'd4;
    e.we    = cond && !bo[2];
    e.ctr   = e.we ? nc : ctr;
    case (k)
      3'd0: e.tag = "R2";
      3'd1: e.tag = "R3";
      3'd4: e.tag = "R5";
      3'd2, 3'd3: e.tag = "R4";
      default: e.tag = "R11";
    endcase
    if (cond && !e.taken) e.tag = "R9";
    return e;
  endfunction

  // One cycle: compare outputs against the model, then drive the next inputs.
  task automatic step(input logic v, input logic [2:0] k, input logic [23:0] li,
      input logic [13:0] bd, input logic [4:0] bo, input logic [4:0] bi,
      input logic [31:0] pc, input logic [31:0] cr, input logic [31:0] ctr,
      input logic [31:0] rg, input logic ordy, input string tag);
    logic acc;
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) begin
      chk({"R10 valid ", q[0].tag}, 32'(out_valid), 32'd1);
      chk({q[0].tag, " taken"}, 32'(out_taken), 32'(q[0].taken));
      chk({q[0].tag, " npc"}, out_npc, q[0].npc);
      chk({q[0].tag, " ctr R6/R7"}, out_ctr, q[0].ctr);
      chk({q[0].tag, " ctr_we R7/R11"}, 32'(out_ctr_we), 32'(q[0].we));
    end else begin
      chk("R10 idle", 32'(out_valid), 32'd0);
    end
    in_valid = v; in_kind = k; in_li = li; in_bd = bd; in_bo = bo; in_bi = bi;
    in_pc = pc; in_cr = cr; in_ctr = ctr; in_reg = rg; out_ready = ordy;
    #1;
    chk("R10 in_ready", 32'(in_ready), 32'(q.size() == 0 || ordy));
    acc = v && (q.size() == 0 || ordy);
    if (q.size() > 0 && ordy) void'(q.pop_front());
    if (acc) begin
      e = model(k, li, bd, bo, bi, pc, cr, ctr, rg);
      if (tag != "") e.tag = tag;
      q.push_back(e);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    // R2: most negative and most positive long displacement
    step(1, 3'd0, 24'h800000, 0, 0, 0, 32'h1000_0000, 0, 5, 0, 1, "R2 neg");
    step(1, 3'd0, 24'h7FFFFF, 0, 0, 0, 32'h0000_0100, 0, 5, 0, 1, "R2 pos");
    // R3: absolute long form
    step(1, 3'd1, 24'hFFFFFF, 0, 0, 0, 32'h4000, 0, 5, 0, 1, "R3 abs");
    // R4: short forms, negative and positive
    step(1, 3'd2, 0, 14'h2000, 5'b10100, 0, 32'h2000, 0, 9, 0, 1, "R4 rel neg");
    step(1, 3'd3, 0, 14'h1FFF, 5'b10100, 0, 32'h2000, 0, 9, 0, 1, "R4 abs pos");
    // R5: register target drops low bits
    step(1, 3'd4, 0, 0, 5'b10100, 0, 32'h10, 0, 9, 32'hDEAD_BEEF, 1, "R5 reg");
    // R6: count untouched
    step(1, 3'd2, 0, 14'h10, 5'b10100, 0, 32'h100, 0, 32'h77, 0, 1, "R6 skip");
    // R7: count 1 -> 0 with zero wanted (taken) and not wanted (not taken, still writes)
    step(1, 3'd2, 0, 14'h10, 5'b10010, 0, 32'h100, 0, 1, 0, 1, "R7 zero taken");
    step(1, 3'd2, 0, 14'h10, 5'b10000, 0, 32'h100, 0, 1, 0, 1, "R7 zero not taken");
    step(1, 3'd3, 0, 14'h10, 5'b10000, 0, 32'h100, 0, 0, 0, 1, "R7 wrap");
    // R8: bit index 0 reads the MSB, index 31 the LSB
    step(1, 3'd2, 0, 14'h10, 5'b01100, 5'd0, 32'h100, 32'h8000_0000, 3, 0, 1, "R8 msb");
    step(1, 3'd2, 0, 14'h10, 5'b01100, 5'd31, 32'h100, 32'h8000_0000, 3, 0, 1, "R8 lsb R9");
    step(1, 3'd2, 0, 14'h10, 5'b00100, 5'd31, 32'h100, 32'h0000_0001, 3, 0, 1, "R8 want0 R9");
    // R11: reserved kind
    step(1, 3'd6, 24'h1, 14'h1, 5'b00000, 0, 32'h300, 32'hFFFF_FFFF, 4, 4, 1, "R11 reserved");
    // R10: stall with a waiting input, then release
    step(1, 3'd1, 24'h40, 0, 0, 0, 0, 0, 0, 0, 0, "R10 stall a");
    step(1, 3'd1, 24'h80, 0, 0, 0, 0, 0, 0, 0, 0, "R10 stall b");
    step(1, 3'd1, 24'h80, 0, 0, 0, 0, 0, 0, 0, 0, "R10 stall b");
    step(1, 3'd1, 24'h80, 0, 0, 0, 0, 0, 0, 0, 1, "R10 stall b");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    // mixed traffic with occasional back-pressure
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 3) != 0, 3'($urandom_range(0, 5)), 24'($urandom),
           14'($urandom), 5'($urandom), 5'($urandom), $urandom, $urandom,
           32'($urandom_range(0, 3)), $urandom, $urandom_range(0, 3) != 0, "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule